// File: doc/BRIEF.md
# Lowest Priority Bus Arbiter

This block lets a local interrupt controller take part in the lowest-priority arbitration phase of a message on a two-wire serial interrupt bus. Another part of the controller handles the message framing. When that part sees the status cycle that calls for lowest-priority delivery, it pulses `arb_start`. The arbiter then captures the processor priority, the bus arbitration ID and a flag that says whether a free interrupt slot exists. During the next twelve bus cycles it contends bit-serially on the wired bus.

The bus is treated as wired-OR, so a driven 1 dominates. Each contender drives the inverted priority first and then the inverted arbitration ID, most significant bit first, on wire 1. Wire 0 is held at 1. A contender that drives 0 and samples 1 on wire 1 leaves the contest for the rest of the phase. The processor with the lowest priority therefore wins, and among equal priorities the lowest ID wins. The remaining contender drives 11 in the status cycle. After one quiet cycle, every contender gets a one-cycle win or lose pulse.

Top module: `lpa_arbiter`

## Requirements
- R1: After reset the block is idle: `bus_out` is 00 and `won` and `lost` are 0.
- R2: `arb_start` sampled high while idle begins a phase on the next cycle. `arb_start` has no effect during the 15 cycles of a running phase.
- R3: In phase cycles 1 to 8, a contender still in the contest drives `bus_out[1]` = NOT `cpu_prio[8-n]` in cycle n (bit 7 first) and drives `bus_out[0]` = 1.
- R4: In phase cycles 9 to 12, a contender still in the contest drives `bus_out[1]` = NOT `bus_id[12-n]` in cycle n (bit 3 first) and drives `bus_out[0]` = 1.
- R5: A contender that drives 0 on wire 1 while `bus_in[1]` is 1 drives 00 for every later cycle of the phase.
- R6: An agent whose `slot_free` was 0 at the start drives 00 for the whole phase and asserts neither `won` nor `lost`.
- R7: In phase cycle 13 the remaining contender drives 11 and every other agent drives 00. In phase cycle 14 all agents drive 00.
- R8: In phase cycle 15 the remaining contender asserts `won` and every other participant asserts `lost`. Each pulse lasts one cycle, and the block is idle in the next cycle.
- R9: `cpu_prio`, `bus_id` and `slot_free` are sampled only in the cycle that starts a phase. Later changes do not alter the bits driven or the outcome.
- R10: On a shared bus with distinct IDs, exactly one participant wins when any take part. The winner has the minimum priority, and among those with the minimum priority it has the minimum ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_start | input | 1 | Pulse: the arbitration phase starts next cycle |
| cpu_prio | input | PRIO_W (8) | Processor priority, captured at start |
| bus_id | input | ID_W (4) | Bus arbitration ID, captured at start |
| slot_free | input | 1 | A free interrupt slot exists; agent takes part |
| bus_in | input | 2 | Sampled wired-OR bus, {wire1, wire0} |
| bus_out | output | 2 | Value this agent contributes to the wired-OR bus |
| won | output | 1 | One-cycle pulse: this agent won arbitration |
| lost | output | 1 | One-cycle pulse: this agent took part and lost |

## Verification
If the phase counter is wrong, the priority bits appear on `bus_out` in the wrong cycle. That is visible in the first arbitration cycle, and the status and report pulses are also shifted. If the contest flag is wrong, either a loser keeps driving 1 bits, which shows on `bus_out` in the cycle after the loss, or the winner goes silent, which leaves a shared bus with no `won` pulse in cycle 15. If the captured word is corrupted, a wrong bit appears on wire 1 in the cycle that carries that bit. A model in the bench predicts every agent's outputs on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/lpa_pkg.sv
// Shared types for the lowest-priority bus arbiter.
package lpa_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_PRIO   = 3'd1,
        PH_ID     = 3'd2,
        PH_STATUS = 3'd3,
        PH_QUIET  = 3'd4,
        PH_REPORT = 3'd5
    } lpa_phase_e;
endpackage

// File: rtl/lpa_seq.sv
// Phase sequencer: steps through the priority bits, the ID bits, the
// status cycle, the quiet cycle and the report cycle after a start pulse.
// Assumes arb_start is meaningful only while idle; it is ignored elsewhere.
module lpa_seq
    import lpa_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4,
    localparam int TOT   = PRIO_W + ID_W,
    localparam int CW    = $clog2(TOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arb_start,
    output lpa_phase_e      phase,
    output logic [CW-1:0]   bit_sel,
    output logic            load,
    output logic            arb_cyc,
    output logic            status_cyc,
    output logic            report_cyc
);
    localparam logic [CW-1:0] LAST_PRIO = CW'(PRIO_W - 1);
    localparam logic [CW-1:0] LAST_BIT  = CW'(TOT - 1);

    // Advance the phase and the bit counter once per bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_sel <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    bit_sel <= '0;
                    if (arb_start) phase <= PH_PRIO;
                end
                PH_PRIO: begin
                    bit_sel <= bit_sel + 1'b1;
                    if (bit_sel == LAST_PRIO) phase <= PH_ID;
                end
                PH_ID: begin
                    bit_sel <= bit_sel + 1'b1;
                    if (bit_sel == LAST_BIT) phase <= PH_STATUS;
                end
                PH_STATUS: phase <= PH_QUIET;
                PH_QUIET:  phase <= PH_REPORT;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Decode the phase into single-purpose strobes.
    always_comb begin
        load       = (phase == PH_IDLE) && arb_start;
        arb_cyc    = (phase == PH_PRIO) || (phase == PH_ID);
        status_cyc = (phase == PH_STATUS);
        report_cyc = (phase == PH_REPORT);
    end

    p_start_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && arb_start) |=> (phase == PH_PRIO && bit_sel == '0))
        else $error("start did not open the phase");
    p_busy_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && phase != PH_REPORT) |=> (phase != PH_IDLE))
        else $error("phase ended early");
    p_report_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REPORT) |=> (phase == PH_IDLE))
        else $error("report cycle not single");
    p_id_follows_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRIO && bit_sel == LAST_PRIO) |=> (phase == PH_ID))
        else $error("ID cycles did not follow priority cycles");
endmodule

// File: rtl/lpa_word.sv
// Contention word: captures {inverted priority, inverted ID} at start and
// presents the bit selected by the sequencer, most significant first.
// Assumes bit_sel stays below PRIO_W + ID_W while it is used.
module lpa_word #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4,
    localparam int TOT   = PRIO_W + ID_W,
    localparam int CW    = $clog2(TOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic [ID_W-1:0]   bus_id,
    input  logic [CW-1:0]     bit_sel,
    output logic              cur_bit
);
    logic [TOT-1:0] word_q;
    logic [CW-1:0]  pos;

    // Capture the inverted fields only on the start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= {~cpu_prio, ~bus_id};
    end

    // Select the bit for the current arbitration cycle, MSB first.
    always_comb begin
        pos     = CW'(TOT - 1) - bit_sel;
        cur_bit = word_q[pos];
    end

    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q))
        else $error("captured word changed outside start");
endmodule

// File: rtl/lpa_contend.sv
// Contention state for one agent: joins when a slot is free, drives its
// bit onto wire 1 with wire 0 held at 1, and leaves on a lost bit.
// Assumes bus_in is the sampled wired-OR of all agents, this one included.
module lpa_contend (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       slot_free,
    input  logic       arb_cyc,
    input  logic       status_cyc,
    input  logic       cur_bit,
    input  logic [1:0] bus_in,
    output logic [1:0] bus_out,
    output logic       joined,
    output logic       in_race
);
    logic lost_bit;

    // A driven 0 overruled by a 1 on the bus means this agent is out.
    always_comb lost_bit = arb_cyc && in_race && !cur_bit && bus_in[1];

    // Track participation and whether the agent is still contending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            joined  <= 1'b0;
            in_race <= 1'b0;
        end else if (load) begin
            joined  <= slot_free;
            in_race <= slot_free;
        end else if (lost_bit) begin
            in_race <= 1'b0;
        end
    end

    // Contribute to the wired-OR bus: bit plus 1 while contending, 11 in status.
    always_comb begin
        if (arb_cyc && in_race)         bus_out = {cur_bit, 1'b1};
        else if (status_cyc && in_race) bus_out = 2'b11;
        else                            bus_out = 2'b00;
    end

    p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_race) && $past(arb_cyc)) |-> ($past(bus_in[1]) && !$past(cur_bit)))
        else $error("left the contest without losing a bit");
    p_drop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_cyc && !in_race) |=> !in_race)
        else $error("rejoined after dropping out");
    p_wire0_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_cyc && in_race) |-> bus_out[0])
        else $error("wire 0 not held at 1 while contending");
    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !joined |-> (bus_out == 2'b00))
        else $error("non-participant drove the bus");
endmodule

// File: rtl/lpa_arbiter.sv
// Lowest-priority bus arbiter top: wires the sequencer, the contention
// word and the contention state, and produces the win/lose pulses.
// Assumes arb_start follows the status cycle that calls for arbitration.
module lpa_arbiter #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_start,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic [ID_W-1:0]   bus_id,
    input  logic              slot_free,
    input  logic [1:0]        bus_in,
    output logic [1:0]        bus_out,
    output logic              won,
    output logic              lost
);
    import lpa_pkg::*;
    localparam int TOT = PRIO_W + ID_W;
    localparam int CW  = $clog2(TOT);

    lpa_phase_e    phase;
    logic [CW-1:0] bit_sel;
    logic          load, arb_cyc, status_cyc, report_cyc;
    logic          cur_bit, joined, in_race;

    lpa_seq #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .arb_start(arb_start),
        .phase(phase), .bit_sel(bit_sel), .load(load),
        .arb_cyc(arb_cyc), .status_cyc(status_cyc), .report_cyc(report_cyc)
    );

    lpa_word #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_word (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cpu_prio(cpu_prio), .bus_id(bus_id), .bit_sel(bit_sel),
        .cur_bit(cur_bit)
    );

    lpa_contend u_contend (
        .clk(clk), .rst_n(rst_n), .load(load), .slot_free(slot_free),
        .arb_cyc(arb_cyc), .status_cyc(status_cyc), .cur_bit(cur_bit),
        .bus_in(bus_in), .bus_out(bus_out), .joined(joined), .in_race(in_race)
    );

    // Report the outcome in the cycle after the quiet cycle.
    always_comb begin
        won  = report_cyc && in_race;
        lost = report_cyc && joined && !in_race;
    end

    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && lost))
        else $error("won and lost together");
    p_win_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        won |=> !won)
        else $error("win pulse longer than one cycle");
    p_lose_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !lost)
        else $error("lose pulse longer than one cycle");
    p_quiet_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_cyc |=> (bus_out == 2'b00))
        else $error("bus driven in quiet cycle");
endmodule

// File: tb/test_lpa_arbiter.sv
`timescale 1ns/1ps
module test_lpa_arbiter;
    localparam int NAG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] prio [NAG];
    logic [3:0] id   [NAG];
    logic       slot [NAG];
    logic [1:0] outs [NAG];
    logic       won  [NAG];
    logic       lost [NAG];
    logic [1:0] bus;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string win_tag = "R10";

    // reference model state
    int        mt = 0;
    bit [11:0] mvec [NAG];
    bit        mrace [NAG];
    bit        mpart [NAG];
    int        lp [NAG];
    int        li [NAG];

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NAG; g++) begin : g_ag
        lpa_arbiter i_lpa_arbiter (
            .clk(clk), .rst_n(rst_n), .arb_start(start),
            .cpu_prio(prio[g]), .bus_id(id[g]), .slot_free(slot[g]),
            .bus_in(bus), .bus_out(outs[g]), .won(won[g]), .lost(lost[g])
        );
    end

    always_comb begin
        bus = 2'b00;
        for (int a = 0; a < NAG; a++) bus = bus | outs[a];
    end

    // Behavioural model, advanced once per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            mt = 0;
            for (int a = 0; a < NAG; a++) begin mrace[a] = 0; mpart[a] = 0; end
        end else if (mt == 0) begin
            if (start) begin
                mt = 1;
                for (int a = 0; a < NAG; a++) begin
                    mvec[a]  = {~prio[a], ~id[a]};
                    mpart[a] = slot[a];
                    mrace[a] = slot[a];
                    lp[a] = prio[a];
                    li[a] = id[a];
                end
            end
        end else begin
            if (mt <= 12) begin
                bit b1;
                b1 = 0;
                for (int a = 0; a < NAG; a++) if (mrace[a] && mvec[a][12-mt]) b1 = 1;
                for (int a = 0; a < NAG; a++) if (mrace[a] && !mvec[a][12-mt] && b1) mrace[a] = 0;
            end
            mt = (mt == 15) ? 0 : mt + 1;
        end
    end

    // Compare every agent against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int a = 0; a < NAG; a++) begin
                logic [1:0] eo;
                logic ew, el;
                string tag;
                if (mt >= 1 && mt <= 12 && mrace[a]) eo = {mvec[a][12-mt], 1'b1};
                else if (mt == 13 && mrace[a])       eo = 2'b11;
                else                                 eo = 2'b00;
                ew = (mt == 15) && mrace[a];
                el = (mt == 15) && mpart[a] && !mrace[a];
                if (mt == 0)                  tag = "R2";
                else if (!mpart[a])           tag = "R6";
                else if (mt <= 12 && !mrace[a]) tag = "R5";
                else if (mt <= 8)             tag = "R3";
                else if (mt <= 12)            tag = "R4";
                else if (mt <= 14)            tag = "R7";
                else                          tag = "R8";
                compared++;
                if (outs[a] !== eo || won[a] !== ew || lost[a] !== el) begin
                    mismatched++;
                    $display("FAIL %s agent %0d t=%0d: out=%b won=%b lost=%b expected out=%b won=%b lost=%b",
                             tag, a, mt, outs[a], won[a], lost[a], eo, ew, el);
                end
            end
            if (mt == 15) begin
                int best, nwin;
                best = -1; nwin = 0;
                for (int a = 0; a < NAG; a++) begin
                    if (won[a] === 1'b1) nwin++;
                    if (mpart[a] && (best < 0 || lp[a] < lp[best] ||
                        (lp[a] == lp[best] && li[a] < li[best]))) best = a;
                end
                compared++;
                if ((best < 0 && nwin != 0) ||
                    (best >= 0 && (nwin != 1 || won[best] !== 1'b1))) begin
                    mismatched++;
                    $display("FAIL %s winners=%0d expected agent %0d alone", win_tag, nwin, best);
                end
            end
        end
    end

    task automatic set_agent(int a, int p, int i, bit s);
        prio[a] = 8'(p); id[a] = 4'(i); slot[a] = s;
    endtask

    task automatic round();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NAG; a++) set_agent(a, 0, a, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < NAG; a++) begin
            compared++;
            if (outs[a] !== 2'b00 || won[a] !== 1'b0 || lost[a] !== 1'b0) begin
                mismatched++;
                $display("FAIL R1 agent %0d out=%b won=%b lost=%b expected 00 0 0", a, outs[a], won[a], lost[a]);
            end
        end
        @(negedge clk) rst_n = 1'b1;

        // distinct priorities (R3, R5, R10)
        set_agent(0, 8'h40, 2, 1); set_agent(1, 8'h13, 5, 1);
        set_agent(2, 8'h90, 1, 1); set_agent(3, 8'h14, 7, 1);
        round();
        // equal priority, tie on ID (R4)
        set_agent(0, 8'h22, 9, 1); set_agent(1, 8'h22, 3, 1);
        set_agent(2, 8'h22, 12, 1); set_agent(3, 8'h80, 0, 1);
        round();
        // lowest priority has no free slot (R6)
        set_agent(0, 8'h00, 0, 0); set_agent(1, 8'h55, 4, 1);
        set_agent(2, 8'hAA, 6, 1); set_agent(3, 8'h56, 2, 1);
        round();
        // nobody has a slot (R6)
        for (int a = 0; a < NAG; a++) set_agent(a, a, a, 1'b0);
        round();
        // single participant wins alone (R8)
        set_agent(2, 8'hFF, 15, 1);
        round();
        // inputs and start change during the phase (R9, R2)
        win_tag = "R9";
        set_agent(0, 8'h30, 1, 1); set_agent(1, 8'h31, 2, 1);
        set_agent(2, 8'h30, 0, 1); set_agent(3, 8'h70, 3, 0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        set_agent(1, 8'h00, 0, 1); set_agent(3, 8'h00, 0, 1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        win_tag = "R10";
        // random rounds with many priority ties
        for (int r = 0; r < 12; r++) begin
            for (int a = 0; a < NAG; a++)
                set_agent(a, int'($urandom_range(0, 3)), (a * 5 + r) % 16, ($urandom % 4) != 0);
            round();
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule